// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block decides which pending interrupt source a small 8-bit CPU core should service next. Each source has a pending flag, an enable bit and a priority bit that selects a high or a low level. The block samples the masked pending flags on every clock and keeps a record of which priority levels are currently in service. It raises one request, together with the index of the chosen source, when the CPU reaches an instruction boundary. A high-level source may interrupt a low-level routine, which gives one level of nesting. Nothing interrupts a high-level routine.

The CPU reports three events: an instruction boundary (`insn_done`), the acceptance of the vector (`vec_ack`) and the execution of a return from interrupt (`reti`). After a return, the block lets at least one more instruction finish before it raises the next request. Building the call sequence, computing vector addresses and clearing source flags are the job of the surrounding core.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `irq_req` is 0, `irq_idx` is 0 and `in_svc` is 2'b00.
- R2: Pending flags, masked by their enables, are registered at every rising edge. With `insn_done` held high and nothing in service, a flag that rises between two edges is captured at the first edge that follows, and `irq_req` rises at the second.
- R3: `irq_req` rises only at an edge where `insn_done` is 1, `glob_en` is 1 and at least one eligible source has its enable bit set. A source whose enable bit is 0 never produces a request.
- R4: When several eligible sources are pending, any high-level source (priority bit 1) is chosen over every low-level source. Among sources of the same level, the one with the lowest index wins.
- R5: While only the low level is in service, a pending high-level source raises a request. Once it is acknowledged, `in_svc` reads 2'b11, where bit 1 is the high level and bit 0 is the low level.
- R6: While the high level is in service, no request is raised. While only the low level is in service, no low-level source raises a request.
- R7: A request stays high until `vec_ack`, and `irq_idx` does not change while it waits, even if other sources become pending. At the acknowledge edge, `irq_req` drops and the `in_svc` bit for the chosen source's level is set.
- R8: A `reti` pulse clears `in_svc[1]` if it is set and leaves `in_svc[0]` unchanged. Otherwise it clears `in_svc[0]`.
- R9: No request rises at the edge where `reti` is sampled, nor at the first later edge with `insn_done` high. The earliest request after a return is at the second such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | N_SRC | Per-source pending flags |
| src_en | input | N_SRC | Per-source enable bits |
| src_hi | input | N_SRC | Per-source priority bits (1 = high) |
| glob_en | input | 1 | Global interrupt enable |
| insn_done | input | 1 | Instruction boundary strobe |
| vec_ack | input | 1 | CPU has taken the vector of the current request |
| reti | input | 1 | CPU executed a return from interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | $clog2(N_SRC) | Index of the requested source |
| in_svc | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The assertions assume that the CPU follows the handshake. `vec_ack` is only pulsed while `irq_req` is high, and never in the same cycle as `reti`. A `reti` is only issued while some level is in service. The stimulus respects all three rules: every acknowledge is sent only after the bench has seen the request, each strobe is a single cycle, and every return is paired with an earlier acknowledge. Priority and enable bits change only while no sampled request depends on them.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   // In-service record: one flag per priority level
   typedef struct packed {
      logic hi;
      logic lo;
   } svc_t;

   localparam int unsigned IRQ_MIN_SRC = 2;
   localparam int unsigned IRQ_MAX_SRC = 32;

endpackage

// File: rtl/irq_sample_pick.sv
module irq_sample_pick #(
   parameter int unsigned N_SRC = 8,
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] pend,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] prio_hi,
   output logic             hi_any,
   output logic             lo_any,
   output logic [IDX_W-1:0] hi_idx,
   output logic [IDX_W-1:0] lo_idx
);

   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] hi_vec;
   logic [N_SRC-1:0] lo_vec;

   // detection stage: one register per source
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend & en;
   end

   // split each sampled source into its level
   for (genvar g = 0; g < N_SRC; g++) begin : g_level
      assign hi_vec[g] = pend_q[g] &  prio_hi[g];
      assign lo_vec[g] = pend_q[g] & ~prio_hi[g];
   end

   assign hi_any = |hi_vec;
   assign lo_any = |lo_vec;

   // fixed order: lowest index wins, scan from the top down
   always_comb begin
      hi_idx = '0;
      lo_idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (hi_vec[i]) hi_idx = IDX_W'(i);
         if (lo_vec[i]) lo_idx = IDX_W'(i);
      end
   end

   // winner must be a sampled source of its own level (R4)
   assert_pick_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_any |-> (pend_q[hi_idx] && prio_hi[hi_idx]));

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
   import irq_nest_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic reti,
   input  logic insn_done,
   output svc_t svc,
   output logic ret_block
);

   // in-service levels
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         svc <= '0;
      end else if (reti) begin
         if (svc.hi) svc.hi <= 1'b0;
         else        svc.lo <= 1'b0;
      end else if (take) begin
         if (take_hi) svc.hi <= 1'b1;
         else         svc.lo <= 1'b1;
      end
   end

   // one instruction must complete after a return
   always_ff @(posedge clk) begin
      if (!rst_n)         ret_block <= 1'b0;
      else if (reti)      ret_block <= 1'b1;
      else if (insn_done) ret_block <= 1'b0;
   end

   assert_reti_hi_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && svc.hi) |=> (!svc.hi && (svc.lo == $past(svc.lo))));

   assert_reti_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !svc.hi) |=> !svc.lo);

   assert_take_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !reti) |=> (take_hi ? svc.hi : svc.lo));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_pend,
   input  logic [N_SRC-1:0] src_en,
   input  logic [N_SRC-1:0] src_hi,
   input  logic             glob_en,
   input  logic             insn_done,
   input  logic             vec_ack,
   input  logic             reti,
   output logic             irq_req,
   output logic [IDX_W-1:0] irq_idx,
   output logic [1:0]       in_svc
);

   if (N_SRC < IRQ_MIN_SRC || N_SRC > IRQ_MAX_SRC) begin : g_bad_cfg
      $error("irq_nest_ctrl: N_SRC out of supported range");
   end

   logic             hi_any, lo_any;
   logic [IDX_W-1:0] hi_idx, lo_idx;
   svc_t             svc;
   logic             ret_block;
   logic             req_q, lvl_q;
   logic [IDX_W-1:0] idx_q;
   logic             hi_ok, lo_ok, raise, take;

   irq_sample_pick #(.N_SRC(N_SRC)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (src_pend),
      .en      (src_en),
      .prio_hi (src_hi),
      .hi_any  (hi_any),
      .lo_any  (lo_any),
      .hi_idx  (hi_idx),
      .lo_idx  (lo_idx)
   );

   assign take = req_q & vec_ack;

   irq_svc_track u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .take_hi   (lvl_q),
      .reti      (reti),
      .insn_done (insn_done),
      .svc       (svc),
      .ret_block (ret_block)
   );

   // eligibility against the in-service state
   assign hi_ok = hi_any & ~svc.hi;
   assign lo_ok = lo_any & ~svc.hi & ~svc.lo;
   assign raise = ~req_q & insn_done & glob_en & ~ret_block & ~reti & (hi_ok | lo_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
         lvl_q <= 1'b0;
      end else if (raise) begin
         req_q <= 1'b1;
         idx_q <= hi_ok ? hi_idx : lo_idx;
         lvl_q <= hi_ok;
      end else if (take) begin
         req_q <= 1'b0;
      end
   end

   assign irq_req = req_q;
   assign irq_idx = idx_q;
   assign in_svc  = {svc.hi, svc.lo};

   assert_raise_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(insn_done) && $past(glob_en)));

   assert_no_raise_in_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> !$past(in_svc[1]));

   assert_hold_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !vec_ack) |=> (irq_req && $stable(irq_idx)));

   assert_post_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reti) |-> !$rose(irq_req));

endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] src_pend, src_en, src_hi;
   logic         glob_en, insn_done, vec_ack, reti;
   logic         irq_req;
   logic [2:0]   irq_idx;
   logic [1:0]   in_svc;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   int    exp_idx_q[$];
   string exp_tag_q[$];
   logic  req_prev = 1'b0;

   always #10 clk = ~clk;

   irq_nest_ctrl #(.N_SRC(N)) i_irq_nest_ctrl (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
      .src_hi(src_hi), .glob_en(glob_en), .insn_done(insn_done),
      .vec_ack(vec_ack), .reti(reti), .irq_req(irq_req),
      .irq_idx(irq_idx), .in_svc(in_svc)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic pulse_ack();
      vec_ack = 1'b1; tick(1); vec_ack = 1'b0;
   endtask

   task automatic pulse_reti();
      reti = 1'b1; tick(1); reti = 1'b0;
   endtask

   // driver side of the scoreboard
   task automatic expect_grant(input int idx, input string tag);
      exp_idx_q.push_back(idx);
      exp_tag_q.push_back(tag);
   endtask

   // monitor: every new request is compared with the next expected grant
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (irq_req && !req_prev) begin
            if (exp_idx_q.size() == 0) begin
               chk("R3 unexpected request", int'(irq_idx), -1);
            end else begin
               int    e;
               string t;
               e = exp_idx_q.pop_front();
               t = exp_tag_q.pop_front();
               chk(t, int'(irq_idx), e);
            end
         end
         req_prev = irq_req;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      rst_n = 1'b0; src_pend = '0; src_en = '1; src_hi = '0;
      glob_en = 1'b1; insn_done = 1'b1; vec_ack = 1'b0; reti = 1'b0;
      tick(3);
      chk("R1 req in reset", int'(irq_req), 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 req", int'(irq_req), 0);
      chk("R1 idx", int'(irq_idx), 0);
      chk("R1 svc", int'(in_svc), 0);

      // R2 detection latency
      src_pend[3] = 1'b1; expect_grant(3, "R2 grant idx");
      tick(1); chk("R2 not before sample", int'(irq_req), 0);
      tick(1); chk("R2 raised", int'(irq_req), 1);
      chk("R2 idx", int'(irq_idx), 3);
      src_pend[3] = 1'b0; pulse_ack();
      chk("R7 drop on ack", int'(irq_req), 0);
      chk("R7 low marked", int'(in_svc), 1);

      // R6 low held off by low
      src_pend[1] = 1'b1; tick(4);
      chk("R6 low held off", int'(irq_req), 0);

      // R5 high preempts low
      src_hi[5] = 1'b1; src_pend[5] = 1'b1; expect_grant(5, "R5 preempt idx");
      tick(2); chk("R5 preempt req", int'(irq_req), 1);
      src_pend[5] = 1'b0; pulse_ack();
      chk("R5 nested svc", int'(in_svc), 3);

      // R6 nothing preempts high
      src_hi[6] = 1'b1; src_pend[6] = 1'b1; tick(4);
      chk("R6 high not preempted", int'(irq_req), 0);

      // R8 / R9 return handling
      insn_done = 1'b0; pulse_reti();
      chk("R8 high cleared first", int'(in_svc), 1);
      tick(3); chk("R9 no boundary yet", int'(irq_req), 0);
      insn_done = 1'b1; expect_grant(6, "R9 grant idx");
      tick(1); chk("R9 first instruction", int'(irq_req), 0);
      tick(1); chk("R9 second boundary", int'(irq_req), 1);
      src_pend[6] = 1'b0; pulse_ack();
      chk("R7 high marked", int'(in_svc), 3);
      pulse_reti(); chk("R8 high cleared", int'(in_svc), 1);
      tick(1); chk("R6 low still held", int'(irq_req), 0);
      pulse_reti(); chk("R8 low cleared", int'(in_svc), 0);
      expect_grant(1, "R9 low after return");
      tick(1); chk("R9 blocked one insn", int'(irq_req), 0);
      tick(1); chk("R9 low raised", int'(irq_req), 1);
      src_pend[1] = 1'b0; pulse_ack(); pulse_reti(); tick(2);
      chk("R8 idle again", int'(in_svc), 0);

      // R4 simultaneous sources
      src_hi[4] = 1'b1;
      src_pend[1] = 1'b1; src_pend[4] = 1'b1; src_pend[6] = 1'b1;
      expect_grant(4, "R4 high lowest idx");
      tick(2); chk("R4 req", int'(irq_req), 1);
      src_pend[4] = 1'b0; pulse_ack();
      chk("R7 only high", int'(in_svc), 2);
      tick(3); chk("R6 high pending blocked", int'(irq_req), 0);
      pulse_reti(); expect_grant(6, "R4 next high");
      tick(2); src_pend[6] = 1'b0; pulse_ack(); pulse_reti();
      expect_grant(1, "R4 low last");
      tick(2); src_pend[1] = 1'b0; pulse_ack(); pulse_reti(); tick(2);

      // R4 tie within low level
      src_hi = '0;
      src_pend[7] = 1'b1; src_pend[2] = 1'b1;
      expect_grant(2, "R4 low tie idx");
      tick(2); src_pend[2] = 1'b0; pulse_ack(); pulse_reti();
      expect_grant(7, "R4 remaining low");
      tick(2); chk("R4 second low req", int'(irq_req), 1);
      src_pend[7] = 1'b0; pulse_ack(); pulse_reti(); tick(2);

      // R3 enables
      src_en[3] = 1'b0; src_pend[3] = 1'b1; tick(4);
      chk("R3 source disabled", int'(irq_req), 0);
      src_en[3] = 1'b1; glob_en = 1'b0; tick(4);
      chk("R3 global disabled", int'(irq_req), 0);
      glob_en = 1'b1; expect_grant(3, "R3 enabled grant");
      tick(1); chk("R3 raised", int'(irq_req), 1);

      // R7 index held while waiting
      src_hi[0] = 1'b1; src_pend[0] = 1'b1; tick(3);
      chk("R7 req held", int'(irq_req), 1);
      chk("R7 idx held", int'(irq_idx), 3);
      src_pend[3] = 1'b0; pulse_ack();
      chk("R7 low marked again", int'(in_svc), 1);
      expect_grant(0, "R5 preempt after ack");
      tick(1); chk("R5 raised after ack", int'(irq_req), 1);
      src_pend[0] = 1'b0; pulse_ack();
      chk("R5 both levels", int'(in_svc), 3);
      pulse_reti(); pulse_reti(); tick(3);
      chk("R8 all cleared", int'(in_svc), 0);

      chk("R7 scoreboard drained", exp_idx_q.size(), 0);
      summary();
   end

endmodule